// File: doc/BRIEF.md
# Host Controller Interrupt Register Block

This block collects event pulses from the core logic of a USB host controller and turns them into a set of sticky status bits that software can read. It also drives one level-sensitive interrupt request. The events are scheduling overrun, done-head writeback, start of frame, resume detection, unrecoverable error, frame-number wrap, root hub change and ownership change. Each event arrives as a single-cycle pulse. The exception is resume, which arrives as a level, and the block detects its rising edge.

Software reaches the block through a word-wide register port with a combinational read. The register map has three locations:
- A status location, where writing 1 to a bit clears that bit.
- An enable-set location, where writing 1 to a bit sets that enable bit.
- An enable-clear location, where writing 1 to a bit clears that enable bit.

Bit 31 of the enable word is a master gate on the interrupt request. While the done-head status bit is set, a stall output tells the controller to hold back any further done-head writeback.

Top module: `hc_irq_regs`

## Requirements
- R1: After synchronous reset, all status bits and all enable bits are 0, and both irq_o and done_stall_o are low.
- R2: A one-cycle event pulse sets its status bit from the next clock edge, and the bit stays set. The bit positions are: scheduling overrun 0, done-head writeback 1, frame start 2, resume 3, unrecoverable error 4, frame wrap 5, hub change 6, owner change 30.
- R3: A write to the status address (0) clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. No software write can set a status bit.
- R4: If an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the enable-set address (1) sets each enable bit whose data bit is 1, and data bits of 0 leave their enable bits unchanged. Reads of address 1 and of address 2 both return the current enable word.
- R6: A write to the enable-clear address (2) clears each enable bit whose data bit is 1. This includes the master enable at bit 31.
- R7: irq_o is high exactly when enable bit 31 is set and at least one status bit has its matching enable bit set. irq_o follows the register state with no extra delay.
- R8: done_stall_o is high exactly while status bit 1 is set.
- R9: Status bit 3 sets only on a 0-to-1 transition of resume_signal. Holding resume_signal high does not set the bit again after software has cleared it.
- R10: With SMI_EN = 0, status bit 30 always reads 0, even when owner-change pulses arrive.
- R11: Reserved bit positions always read 0, and writes to them have no effect. Address 3 reads 0, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_sched_overrun | input | 1 | Scheduling overrun pulse |
| ev_done_writeback | input | 1 | Done-head writeback pulse |
| ev_frame_start | input | 1 | Start-of-frame pulse |
| resume_signal | input | 1 | Resume signalling level from the bus |
| ev_unrecoverable | input | 1 | Unrecoverable system error pulse |
| ev_frame_wrap | input | 1 | Frame number MSB toggle pulse |
| ev_hub_change | input | 1 | Root hub status change pulse |
| ev_owner_change | input | 1 | Ownership change request pulse |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Level interrupt request |
| done_stall_o | output | 1 | Hold-off for further done-head writebacks |

## Verification
Most faults in this block show up at the ports one clock edge after the stimulus that triggers them. Examples are a status bit that fails to latch, a clear that is applied too widely, or an enable bit that cannot be cleared. These faults appear either in the read data of the affected address or in irq_o and done_stall_o, which the bench compares against its own register model on every cycle. Slower faults need a read of the affected word to appear. These include a resume detector that responds to the level instead of the edge, and a reserved bit that keeps a written value. Directed sequences perform those reads.

// File: rtl/hcint_pkg.sv
package hcint_pkg;

    localparam int REG_W = 32;

    // Status bit positions (enable word uses the same positions)
    localparam int BIT_SCHED  = 0;
    localparam int BIT_DONE   = 1;
    localparam int BIT_SOF    = 2;
    localparam int BIT_RESUME = 3;
    localparam int BIT_UNREC  = 4;
    localparam int BIT_FWRAP  = 5;
    localparam int BIT_HUB    = 6;
    localparam int BIT_OWNER  = 30;
    localparam int BIT_MASTER = 31;

    typedef struct packed {
        logic sched_overrun;
        logic done_writeback;
        logic frame_start;
        logic unrecoverable;
        logic frame_wrap;
        logic hub_change;
        logic owner_change;
    } hc_events_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             wr_status;
        logic             wr_en_set;
        logic             wr_en_clr;
        logic [REG_W-1:0] data;
    } reg_cmd_t;

    // Implemented status positions
    function automatic logic [REG_W-1:0] status_impl_mask(input bit smi);
        logic [REG_W-1:0] m;
        m = '0;
        m[BIT_SCHED]  = 1'b1;
        m[BIT_DONE]   = 1'b1;
        m[BIT_SOF]    = 1'b1;
        m[BIT_RESUME] = 1'b1;
        m[BIT_UNREC]  = 1'b1;
        m[BIT_FWRAP]  = 1'b1;
        m[BIT_HUB]    = 1'b1;
        m[BIT_OWNER]  = smi;
        return m;
    endfunction

    // Implemented enable positions: status positions plus master gate
    function automatic logic [REG_W-1:0] enable_impl_mask(input bit smi);
        logic [REG_W-1:0] m;
        m = status_impl_mask(smi);
        m[BIT_MASTER] = 1'b1;
        return m;
    endfunction

    // Map event pulses onto status positions
    function automatic logic [REG_W-1:0] event_vector(input hc_events_t ev,
                                                      input logic resume_rise);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_SCHED]  = ev.sched_overrun;
        v[BIT_DONE]   = ev.done_writeback;
        v[BIT_SOF]    = ev.frame_start;
        v[BIT_RESUME] = resume_rise;
        v[BIT_UNREC]  = ev.unrecoverable;
        v[BIT_FWRAP]  = ev.frame_wrap;
        v[BIT_HUB]    = ev.hub_change;
        v[BIT_OWNER]  = ev.owner_change;
        return v;
    endfunction

endpackage

// File: rtl/hcint_decode.sv
module hcint_decode
    import hcint_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int STATUS_ADDR = 0,
    parameter int EN_SET_ADDR = 1,
    parameter int EN_CLR_ADDR = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output reg_sel_e          sel,
    output reg_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(EN_SET_ADDR);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(EN_CLR_ADDR);

    always_comb begin
        if (addr == A_STATUS)      sel = SEL_STATUS;
        else if (addr == A_EN_SET) sel = SEL_EN_SET;
        else if (addr == A_EN_CLR) sel = SEL_EN_CLR;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        cmd.wr_status = wr && (sel == SEL_STATUS);
        cmd.wr_en_set = wr && (sel == SEL_EN_SET);
        cmd.wr_en_clr = wr && (sel == SEL_EN_CLR);
        cmd.data      = wdata;
    end

endmodule

// File: rtl/hcint_status.sv
module hcint_status
    import hcint_pkg::*;
#(
    parameter bit SMI_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  hc_events_t       events,
    input  logic             resume_in,
    input  logic             wr_clear,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] status_q
);

    localparam logic [REG_W-1:0] IMPL = status_impl_mask(SMI_EN);

    logic             resume_q;
    logic             resume_rise;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] status_d;

    always_ff @(posedge clk) begin
        if (rst) resume_q <= 1'b0;
        else     resume_q <= resume_in;
    end

    assign resume_rise = resume_in & ~resume_q;
    assign set_vec     = event_vector(events, resume_rise) & IMPL;
    assign clr_vec     = wr_clear ? clr_data : '0;

    // Set has priority over a same-cycle clear
    always_comb begin
        status_d = ((status_q & ~clr_vec) | set_vec) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    // R2: every event lands in its status bit on the next edge
    a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((($past(set_vec)) & ~status_q) == '0));

    // R3: cleared bits without a same-cycle event are gone next cycle
    a_r3_clear_applies: assert property (@(posedge clk) disable iff (rst)
        wr_clear |=> ((status_q & $past(clr_data & ~set_vec)) == '0));

    // R3: no bit rises unless an event asked for it
    a_r3_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

    // R9: a held resume level does not re-set a cleared bit
    a_r9_level_ignored: assert property (@(posedge clk) disable iff (rst)
        (resume_in && resume_q && !status_q[BIT_RESUME]) |=> !status_q[BIT_RESUME]);

    generate
        if (!SMI_EN) begin : g_no_smi
            // R10: owner bit stays zero without the option
            a_r10_owner_tied: assert property (@(posedge clk) disable iff (rst)
                !status_q[BIT_OWNER]);
        end
    endgenerate

endmodule

// File: rtl/hcint_enable.sv
module hcint_enable
    import hcint_pkg::*;
#(
    parameter bit SMI_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] data,
    output logic [REG_W-1:0] en_q
);

    localparam logic [REG_W-1:0] IMPL = enable_impl_mask(SMI_EN);

    logic [REG_W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr_set) en_d = en_d | (data & IMPL);
        if (wr_clr) en_d = en_d & ~data;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    // R5: written ones appear in the enable word
    a_r5_set_applies: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((($past(data) & IMPL) & ~en_q) == '0));

    // R6: written ones vanish from the enable word
    a_r6_clear_applies: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((en_q & $past(data)) == '0));

    // R11: reserved enable positions never hold a one
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (en_q & ~IMPL) == '0);

endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
    import hcint_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int STATUS_ADDR = 0,
    parameter int EN_SET_ADDR = 1,
    parameter int EN_CLR_ADDR = 2,
    parameter bit SMI_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sched_overrun,
    input  logic              ev_done_writeback,
    input  logic              ev_frame_start,
    input  logic              resume_signal,
    input  logic              ev_unrecoverable,
    input  logic              ev_frame_wrap,
    input  logic              ev_hub_change,
    input  logic              ev_owner_change,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o,
    output logic              done_stall_o
);

    hc_events_t       events;
    reg_sel_e         sel;
    reg_cmd_t         cmd;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] en_q;

    always_comb begin
        events.sched_overrun  = ev_sched_overrun;
        events.done_writeback = ev_done_writeback;
        events.frame_start    = ev_frame_start;
        events.unrecoverable  = ev_unrecoverable;
        events.frame_wrap     = ev_frame_wrap;
        events.hub_change     = ev_hub_change;
        events.owner_change   = ev_owner_change;
    end

    hcint_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .EN_SET_ADDR (EN_SET_ADDR),
        .EN_CLR_ADDR (EN_CLR_ADDR)
    ) u_decode (
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .sel   (sel),
        .cmd   (cmd)
    );

    hcint_status #(.SMI_EN(SMI_EN)) u_status (
        .clk       (clk),
        .rst       (rst),
        .events    (events),
        .resume_in (resume_signal),
        .wr_clear  (cmd.wr_status),
        .clr_data  (cmd.data),
        .status_q  (status_q)
    );

    hcint_enable #(.SMI_EN(SMI_EN)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .wr_set (cmd.wr_en_set),
        .wr_clr (cmd.wr_en_clr),
        .data   (cmd.data),
        .en_q   (en_q)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status_q;
            SEL_EN_SET,
            SEL_EN_CLR: reg_rdata = en_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o        = en_q[BIT_MASTER] && (|(status_q & en_q & ~(32'd1 << BIT_MASTER)));
    assign done_stall_o = status_q[BIT_DONE];

    // R7: master gate closed means no request
    a_r7_master_gate: assert property (@(posedge clk) disable iff (rst)
        !en_q[BIT_MASTER] |-> !irq_o);

    // R8: stall persists until software writes a one to bit 1
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
        done_stall_o |=> (done_stall_o || $past(cmd.wr_status && cmd.data[BIT_DONE])));

    // R11: unmapped address reads zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_hc_irq_regs.sv
module sim_hc_irq_regs;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] M_SMASK = 32'h4000_007F;
    localparam logic [31:0] M_EMASK = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ev = 8'h00;
    logic        resume = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1, stall0, stall1;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_status = 32'h0;
    logic [31:0] m_en     = 32'h0;
    logic        m_res_q  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_irq_regs u0 (
        .clk(clk), .rst(rst),
        .ev_sched_overrun(ev[0]), .ev_done_writeback(ev[1]), .ev_frame_start(ev[2]),
        .resume_signal(resume), .ev_unrecoverable(ev[4]), .ev_frame_wrap(ev[5]),
        .ev_hub_change(ev[6]), .ev_owner_change(ev[7]),
        .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rd0), .irq_o(irq0), .done_stall_o(stall0)
    );

    hc_irq_regs #(.SMI_EN(1'b0)) u1 (
        .clk(clk), .rst(rst),
        .ev_sched_overrun(ev[0]), .ev_done_writeback(ev[1]), .ev_frame_start(ev[2]),
        .resume_signal(resume), .ev_unrecoverable(ev[4]), .ev_frame_wrap(ev[5]),
        .ev_hub_change(ev[6]), .ev_owner_change(ev[7]),
        .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rd1), .irq_o(irq1), .done_stall_o(stall1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:       return m_status;
            2'd1, 2'd2: return m_en;
            default:    return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_en[31] && (|(m_status & m_en & 32'h7FFF_FFFF));
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R3 status read";
            2'd1:    return "R5 enable read";
            2'd2:    return "R6 enable read via clear address";
            default: return "R11 unmapped read";
        endcase
    endfunction

    // Drive one cycle at the falling edge, check, advance the model
    task automatic cyc(input logic [7:0] e, input logic res, input logic w,
                       input logic [1:0] a, input logic [31:0] d);
        logic [31:0] setv, clr, ns, ne;
        logic        rise;
        ev = e; resume = res; wr = w; addr = a; wdata = d;
        #1;
        chk(rd0 == m_read(a), rd_tag(a), rd0, m_read(a));
        chk(irq0 == m_irq(), "R7 irq level", {31'b0, irq0}, {31'b0, m_irq()});
        chk(stall0 == m_status[1], "R8 stall level", {31'b0, stall0}, {31'b0, m_status[1]});
        rise = res & ~m_res_q;
        setv = {1'b0, e[7], 23'b0, e[6:4], rise, e[2:0]};
        clr  = (w && a == 2'd0) ? d : 32'h0;
        ns   = ((m_status & ~clr) | setv) & M_SMASK;
        ne   = m_en;
        if (w && a == 2'd1) ne = ne | (d & M_EMASK);
        if (w && a == 2'd2) ne = ne & ~d;
        @(posedge clk);
        m_status = ns; m_en = ne; m_res_q = res;
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a);
        ev = 8'h00; wr = 1'b0; addr = a; wdata = 32'h0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd51966));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a));
            chk(rd0 == 32'h0, "R1 reset read u0", rd0, 32'h0);
            chk(rd1 == 32'h0, "R1 reset read u1", rd1, 32'h0);
        end
        chk(irq0 == 1'b0 && stall0 == 1'b0, "R1 reset outputs", {30'b0, irq0, stall0}, 32'h0);

        // R2: every event source at once
        cyc(8'hF7, 1'b0, 1'b0, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h4000_0077, "R2 events latched", rd0, 32'h4000_0077);
        chk(stall0 == 1'b1, "R8 stall after done event", {31'b0, stall0}, 32'h1);
        chk(rd1 == 32'h0000_0077, "R10 owner bit tied off", rd1, 32'h0000_0077);
        cyc(8'h00, 1'b0, 1'b0, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h4000_0077, "R2 bits sticky", rd0, 32'h4000_0077);

        // R3: write-one-to-clear
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h4000_0077, "R3 zero write no effect", rd0, 32'h4000_0077);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 32'h1);
        peek(2'd0);
        chk(rd0 == 32'h4000_0076, "R3 single clear", rd0, 32'h4000_0076);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 32'h2);
        peek(2'd0);
        chk(rd0 == 32'h4000_0074, "R3 done clear", rd0, 32'h4000_0074);
        chk(stall0 == 1'b0, "R8 stall released", {31'b0, stall0}, 32'h0);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        peek(2'd0);
        chk(rd0 == 32'h0, "R3 clear all and no set", rd0, 32'h0);

        // R4: set beats clear
        cyc(8'h04, 1'b0, 1'b1, 2'd0, 32'h4);
        peek(2'd0);
        chk(rd0 == 32'h4, "R4 set wins", rd0, 32'h4);

        // R5 / R7: enable and master gate
        cyc(8'h00, 1'b0, 1'b1, 2'd1, 32'h4);
        peek(2'd1);
        chk(rd0 == 32'h4, "R5 enable set", rd0, 32'h4);
        peek(2'd2);
        chk(rd0 == 32'h4, "R5 enable via clear address", rd0, 32'h4);
        cyc(8'h00, 1'b0, 1'b1, 2'd1, 32'h0);
        peek(2'd1);
        chk(rd0 == 32'h4, "R5 zero write no effect", rd0, 32'h4);
        chk(irq0 == 1'b0, "R7 master off", {31'b0, irq0}, 32'h0);
        cyc(8'h00, 1'b0, 1'b1, 2'd1, 32'h8000_0000);
        peek(2'd1);
        chk(irq0 == 1'b1, "R7 master on", {31'b0, irq0}, 32'h1);

        // R6: clearing the master
        cyc(8'h00, 1'b0, 1'b1, 2'd2, 32'h8000_0000);
        peek(2'd1);
        chk(rd0 == 32'h4, "R6 master cleared", rd0, 32'h4);
        chk(irq0 == 1'b0, "R6 irq drops", {31'b0, irq0}, 32'h0);

        // R11: reserved bits and unmapped address
        cyc(8'h00, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        peek(2'd1);
        chk(rd0 == M_EMASK, "R11 reserved enable bits", rd0, M_EMASK);
        cyc(8'h00, 1'b0, 1'b1, 2'd3, 32'hFFFF_FFFF);
        peek(2'd3);
        chk(rd0 == 32'h0, "R11 unmapped reads zero", rd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h4, "R11 unmapped write ignored status", rd0, 32'h4);
        peek(2'd1);
        chk(rd0 == M_EMASK, "R11 unmapped write ignored enable", rd0, M_EMASK);
        cyc(8'h00, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        peek(2'd1);
        chk(rd0 == 32'h0, "R6 clear all enables", rd0, 32'h0);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);

        // R9: resume edge detection
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h8, "R9 rising edge sets", rd0, 32'h8);
        cyc(8'h00, 1'b1, 1'b1, 2'd0, 32'h8);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h0, "R9 held level ignored", rd0, 32'h0);
        cyc(8'h00, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h8, "R9 new edge sets", rd0, 32'h8);

        // R10: owner change with and without option
        cyc(8'h80, 1'b0, 1'b0, 2'd0, 32'h0);
        peek(2'd0);
        chk(rd0 == 32'h4000_0008, "R2 owner bit position", rd0, 32'h4000_0008);
        chk(rd1 == 32'h0000_0008, "R10 owner tied in u1", rd1, 32'h0000_0008);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  e;
            logic [31:0] d;
            for (int b = 0; b < 8; b++) e[b] = ($urandom_range(0, 7) == 0);
            d = $urandom();
            cyc(e, ($urandom_range(0, 3) == 0) ? ~resume : resume,
                ($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)), d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule